// File: doc/BRIEF.md
# Pulse-Triggered Time Snapshot Unit

This block freezes the value of a free-running real-time clock (a seconds count plus a nanoseconds count) at the moment an external timing pulse arrives. The pulse is asynchronous to the block's clock and normally comes once per second. Hardware does the whole capture with no software step per event. Software only reads the frozen pair, about once per second, through a small register read port.

The pulse passes through a synchronizer chain and a rising-edge detector. On each detected edge, both fields are written into the capture registers in the same clock cycle, so the pair read back always describes one instant. The synchronizer adds delay. To remove it, the unit subtracts a fixed amount from the captured value: the latency in clock ticks times the nanoseconds the clock advances per tick. When that subtraction crosses a second boundary, a borrow is taken from the seconds field.

A sticky flag tells software that a new sample is waiting. A second flag reports that a sample was replaced before software had read it.

Top module: `pps_snap`

## Requirements
- R1: After reset, both flags are 0, the captured seconds and nanoseconds are 0, and `rd_data` is 0.
- R2: A capture happens only on a rising edge of the synchronized pulse. A pulse held high for many cycles gives exactly one capture.
- R3: The captured pair equals the clock value present in the cycle in which the pulse rose. Both fields are loaded in the same cycle. The unit subtracts `LAT_TICKS*NS_PER_TICK` ns (default 2 ticks of 10 ns) to compensate for the synchronizer.
- R4: If the raw nanoseconds value is smaller than the compensation, the captured nanoseconds value is `raw + NS_PER_SEC - compensation`. The captured seconds value is the raw value minus one, wrapping modulo 2^SEC_W.
- R5: The read address selects `rd_data`: 0 gives seconds, 1 gives nanoseconds zero-extended, and 2 gives status with bit 0 = sample ready and bit 1 = sample lost. Address 3 reads 0. `rd_data` is registered: it updates on the clock edge that samples `rd_en` high and otherwise holds its value.
- R6: The sample-ready flag (also the `sample_ready` port) sets on every capture. A read of address 1 clears it. A read of address 0 leaves it set. A capture in the same cycle as the clearing read keeps it set.
- R7: If a capture occurs while sample-ready is set and no address-1 read happens in that cycle, the sample-lost flag (also the `sample_lost` port) sets. The new sample replaces the old one. A read of address 2 clears sample-lost.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock, the same clock that advances the time source |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| pps_in | input | 1 | Asynchronous timing pulse |
| rtc_sec | input | SEC_W | Running seconds count |
| rtc_ns | input | NS_W | Running nanoseconds count, 0 to NS_PER_SEC-1 |
| rd_en | input | 1 | Read strobe |
| rd_addr | input | 2 | Read address |
| rd_data | output | DATA_W | Registered read data |
| sample_ready | output | 1 | A new sample is waiting |
| sample_lost | output | 1 | A sample was replaced before it was read |

## Verification
The bench fires pulses at chosen clock values, including just before a second rollover and at the all-ones seconds value. A design with a wrong latency offset, or one that forgets the borrow, would return a nanoseconds value near 2^30 or a seconds value one too high. Several further cases target specific faults:
- A pulse held high for twenty cycles: a level-triggered capture would raise the lost flag.
- Two pulses with no read in between: these must leave the second sample and the lost flag, and the lost flag must clear only on a status read.
- Seconds reads, idle cycles and address 3: a design that clears the ready flag on the wrong address, or that does not hold the read register, would be caught here.

// File: rtl/pps_snap_pkg.sv
package pps_snap_pkg;
  localparam int ADDR_W = 2;
  localparam logic [ADDR_W-1:0] ADDR_SEC  = 2'd0;
  localparam logic [ADDR_W-1:0] ADDR_NS   = 2'd1;
  localparam logic [ADDR_W-1:0] ADDR_STAT = 2'd2;

  typedef struct packed {
    logic lost;
    logic ready;
  } snap_flags_t;
endpackage

// File: rtl/pps_rst_sync.sv
module pps_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[0], 1'b1};
  end

  assign rst_n_sync = chain_q[1];
endmodule

// File: rtl/pps_edge_sync.sv
module pps_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pulse_async,
  output logic rise
);
  logic [STAGES-1:0] stage_q, stage_d;
  logic              last_q;

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    if (i == 0) begin : g_first
      assign stage_d[i] = pulse_async;
    end else begin : g_next
      assign stage_d[i] = stage_q[i-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= '0;
      last_q  <= 1'b0;
    end else begin
      stage_q <= stage_d;
      last_q  <= stage_q[STAGES-1];
    end
  end

  assign rise = stage_q[STAGES-1] & ~last_q;
endmodule

// File: rtl/pps_capture.sv
module pps_capture
  import pps_snap_pkg::*;
#(
  parameter int SEC_W       = 32,
  parameter int NS_W        = 30,
  parameter int NS_PER_SEC  = 1000000000,
  parameter int NS_PER_TICK = 10,
  parameter int LAT_TICKS   = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cap_fire,
  input  logic [SEC_W-1:0] rtc_sec,
  input  logic [NS_W-1:0]  rtc_ns,
  input  logic             ns_read,
  input  logic             stat_read,
  output logic [SEC_W-1:0] snap_sec,
  output logic [NS_W-1:0]  snap_ns,
  output snap_flags_t      flags
);
  localparam int          LAT_NS = LAT_TICKS * NS_PER_TICK;
  localparam logic [NS_W:0] LAT_V  = (NS_W+1)'(LAT_NS);
  localparam logic [NS_W:0] ROLL_V = (NS_W+1)'(NS_PER_SEC - LAT_NS);

  logic [NS_W:0]    raw_ns, adj_ns;
  logic [SEC_W-1:0] adj_sec;
  logic [SEC_W-1:0] sec_q;
  logic [NS_W-1:0]  ns_q;
  snap_flags_t      flags_q, flags_d;

  // latency compensation with borrow across the second boundary
  always_comb begin
    raw_ns = {1'b0, rtc_ns};
    if (raw_ns >= LAT_V) begin
      adj_ns  = raw_ns - LAT_V;
      adj_sec = rtc_sec;
    end else begin
      adj_ns  = raw_ns + ROLL_V;
      adj_sec = rtc_sec - SEC_W'(1);
    end
  end

  // flag next state: capture has priority over the clearing read
  always_comb begin
    flags_d = flags_q;
    if (ns_read)   flags_d.ready = 1'b0;
    if (stat_read) flags_d.lost  = 1'b0;
    if (cap_fire) begin
      flags_d.ready = 1'b1;
      if (flags_q.ready && !ns_read) flags_d.lost = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sec_q <= '0;
      ns_q  <= '0;
    end else if (cap_fire) begin
      sec_q <= adj_sec;
      ns_q  <= adj_ns[NS_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flags_q <= '0;
    else        flags_q <= flags_d;
  end

  assign snap_sec = sec_q;
  assign snap_ns  = ns_q;
  assign flags    = flags_q;
endmodule

// File: rtl/pps_readport.sv
module pps_readport
  import pps_snap_pkg::*;
#(
  parameter int SEC_W  = 32,
  parameter int NS_W   = 30,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic [SEC_W-1:0]  snap_sec,
  input  logic [NS_W-1:0]   snap_ns,
  input  snap_flags_t       flags,
  output logic              ns_read,
  output logic              stat_read,
  output logic [DATA_W-1:0] rd_data
);
  logic [DATA_W-1:0] rd_d, rd_q;

  assign ns_read   = rd_en && (rd_addr == ADDR_NS);
  assign stat_read = rd_en && (rd_addr == ADDR_STAT);

  always_comb begin
    case (rd_addr)
      ADDR_SEC:  rd_d = DATA_W'(snap_sec);
      ADDR_NS:   rd_d = DATA_W'(snap_ns);
      ADDR_STAT: rd_d = DATA_W'(flags);
      default:   rd_d = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     rd_q <= '0;
    else if (rd_en) rd_q <= rd_d;
  end

  assign rd_data = rd_q;
endmodule

// File: rtl/pps_snap.sv
module pps_snap
  import pps_snap_pkg::*;
#(
  parameter int SEC_W       = 32,
  parameter int NS_W        = 30,
  parameter int DATA_W      = 32,
  parameter int NS_PER_SEC  = 1000000000,
  parameter int NS_PER_TICK = 10,
  parameter int SYNC_STAGES = 2,
  parameter int LAT_TICKS   = SYNC_STAGES
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pps_in,
  input  logic [SEC_W-1:0]  rtc_sec,
  input  logic [NS_W-1:0]   rtc_ns,
  input  logic              rd_en,
  input  logic [1:0]        rd_addr,
  output logic [DATA_W-1:0] rd_data,
  output logic              sample_ready,
  output logic              sample_lost
);
  logic             rst_n_sync;
  logic             cap_fire;
  logic             ns_read, stat_read;
  logic [SEC_W-1:0] snap_sec;
  logic [NS_W-1:0]  snap_ns;
  snap_flags_t      flags;

  pps_rst_sync u_rst (
    .clk(clk), .rst_n(rst_n), .rst_n_sync(rst_n_sync)
  );

  pps_edge_sync #(.STAGES(SYNC_STAGES)) u_edge (
    .clk(clk), .rst_n(rst_n_sync), .pulse_async(pps_in), .rise(cap_fire)
  );

  pps_capture #(
    .SEC_W(SEC_W), .NS_W(NS_W), .NS_PER_SEC(NS_PER_SEC),
    .NS_PER_TICK(NS_PER_TICK), .LAT_TICKS(LAT_TICKS)
  ) u_cap (
    .clk(clk), .rst_n(rst_n_sync), .cap_fire(cap_fire),
    .rtc_sec(rtc_sec), .rtc_ns(rtc_ns),
    .ns_read(ns_read), .stat_read(stat_read),
    .snap_sec(snap_sec), .snap_ns(snap_ns), .flags(flags)
  );

  pps_readport #(.SEC_W(SEC_W), .NS_W(NS_W), .DATA_W(DATA_W)) u_rd (
    .clk(clk), .rst_n(rst_n_sync), .rd_en(rd_en), .rd_addr(rd_addr),
    .snap_sec(snap_sec), .snap_ns(snap_ns), .flags(flags),
    .ns_read(ns_read), .stat_read(stat_read), .rd_data(rd_data)
  );

  assign sample_ready = flags.ready;
  assign sample_lost  = flags.lost;
endmodule

// File: rtl/pps_snap_chk.sv
module pps_snap_chk #(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cap_fire,
  input logic              rd_en,
  input logic [1:0]        rd_addr,
  input logic [DATA_W-1:0] rd_data,
  input logic              sample_ready,
  input logic              sample_lost
);
  // R2
  single_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cap_fire |=> !cap_fire);

  // R6
  ready_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cap_fire |=> sample_ready);

  // R6
  ready_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && rd_addr == 2'd1 && !cap_fire) |=> !sample_ready);

  // R6
  ready_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sample_ready) |-> $past(cap_fire));

  // R7
  lost_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_fire && sample_ready && !(rd_en && rd_addr == 2'd1)) |=> sample_lost);

  // R5
  rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> $stable(rd_data));

  // R5
  rd_unused_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && rd_addr == 2'd3) |=> rd_data == '0);
endmodule

bind pps_snap pps_snap_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cap_fire(cap_fire),
  .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
  .sample_ready(sample_ready), .sample_lost(sample_lost)
);

// File: tb/sim_pps_snap.sv
module sim_pps_snap;
  localparam int NS_PER_SEC = 1000000000;
  localparam int STEP       = 10;

  typedef struct packed {
    logic [31:0] sec;
    logic [29:0] ns;
    logic [31:0] exp_sec;
    logic [29:0] exp_ns;
  } vec_t;

  // stimulus clock value at the pulse, expected captured value (R3, R4)
  localparam vec_t VECS [6] = '{
    '{32'd5,          30'd1000,      32'd5,          30'd1000},
    '{32'd100,        30'd0,         32'd100,        30'd0},
    '{32'd7,          30'd999999990, 32'd7,          30'd999999990},
    '{32'd7,          30'd999999980, 32'd7,          30'd999999980},
    '{32'hFFFFFFFF,   30'd999999990, 32'hFFFFFFFF,   30'd999999990},
    '{32'd12345,      30'd500000000, 32'd12345,      30'd500000000}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        pps_in = 1'b0;
  logic [31:0] rtc_sec = '0;
  logic [29:0] rtc_ns = '0;
  logic        rd_en = 1'b0;
  logic [1:0]  rd_addr = '0;
  logic [31:0] rd_data;
  logic        sample_ready, sample_lost;

  int n_chk = 0;
  int n_err = 0;
  bit done  = 1'b0;

  always #5 clk = ~clk;

  // bench model of the running clock: +10 ns per tick
  always @(posedge clk) begin
    if (rtc_ns >= 30'(NS_PER_SEC - STEP)) begin
      rtc_ns  <= '0;
      rtc_sec <= rtc_sec + 32'd1;
    end else begin
      rtc_ns <= rtc_ns + 30'(STEP);
    end
  end

  pps_snap u0 (
    .clk(clk), .rst_n(rst_n), .pps_in(pps_in),
    .rtc_sec(rtc_sec), .rtc_ns(rtc_ns),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
    .sample_ready(sample_ready), .sample_lost(sample_lost)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [1:0] addr, output logic [31:0] val);
    @(negedge clk);
    rd_en = 1'b1;
    rd_addr = addr;
    @(negedge clk);
    rd_en = 1'b0;
    val = rd_data;
  endtask

  task automatic fire(input logic [31:0] s, input logic [29:0] ns, input int hold);
    @(negedge clk);
    rtc_sec = s;
    rtc_ns  = ns;
    pps_in  = 1'b1;
    repeat (hold) @(negedge clk);
    pps_in = 1'b0;
    repeat (6) @(negedge clk);
  endtask

  initial begin
    logic [31:0] v, held;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    check("R1 rd_data", rd_data, 32'd0);
    check("R1 ready", {31'd0, sample_ready}, 32'd0);
    rd(2'd2, v); check("R1 status", v, 32'd0);
    rd(2'd0, v); check("R1 sec", v, 32'd0);
    rd(2'd1, v); check("R1 ns", v, 32'd0);

    // table walk: R3, R4, R5, R6
    foreach (VECS[i]) begin
      fire(VECS[i].sec, VECS[i].ns, 1);
      check("R6 ready port", {31'd0, sample_ready}, 32'd1);
      rd(2'd2, v); check("R5 status after capture", v, 32'd1);
      rd(2'd0, v); check("R3/R4 sec", v, VECS[i].exp_sec);
      rd(2'd1, v); check("R3/R4 ns", v, {2'b0, VECS[i].exp_ns});
      rd(2'd2, v); check("R6 cleared by ns read", v, 32'd0);
    end

    // R2: held pulse captures once
    fire(32'd40, 30'd2000, 20);
    rd(2'd2, v); check("R2 held pulse single capture", v, 32'd1);
    // R6: seconds read leaves ready set
    rd(2'd0, v); check("R2 sec", v, 32'd40);
    rd(2'd2, v); check("R6 sec read keeps ready", v, 32'd1);
    rd(2'd1, v); check("R2 ns", v, 32'd2000);

    // R7: overrun, newer sample kept, lost cleared by status read
    fire(32'd60, 30'd3000, 1);
    fire(32'd61, 30'd4000, 1);
    check("R7 lost port", {31'd0, sample_lost}, 32'd1);
    rd(2'd2, v); check("R7 status both", v, 32'd3);
    rd(2'd2, v); check("R7 lost cleared by status read", v, 32'd1);
    rd(2'd0, v); check("R7 newer sec", v, 32'd61);
    rd(2'd1, v); check("R7 newer ns", v, 32'd4000);
    rd(2'd2, v); check("R7 all clear", v, 32'd0);

    // R5: hold without strobe, unused address
    rd(2'd1, held);
    repeat (5) @(negedge clk);
    check("R5 hold", rd_data, held);
    rd(2'd3, v); check("R5 unused address", v, 32'd0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end
endmodule